// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Change Interrupts

This block is a 16-pin general-purpose I/O port split into a low half (pins 7..0, half A) and a high half (pins 15..8, half B). Software reaches it through a synchronous register port with a one-cycle read latency. Each pin has a direction bit and an output latch. Its input passes through a two-flop synchronizer and a stability filter. The filtered value can be inverted bit by bit before reads and before interrupt comparison.

Each half runs its own interrupt engine. An enabled input pin raises an interrupt when its value changes from the previous cycle or, if the pin is set to compare mode, when it differs from a default-compare bit. When the interrupt fires, the engine records which pins caused it in a flag register and takes a snapshot of the port. Reading the snapshot or the port register clears the interrupt and re-arms the engine. The two interrupt lines can serve their own halves or be mirrored. Each line can drive active-high, active-low, or as an open-drain pull-down.

Each half's engine is a small state machine. After reset it sits in IOC_IDLE for one cycle while it loads the previous-value baseline, then moves to IOC_ARMED. In IOC_ARMED, any enabled mismatch moves it to IOC_FIRED, unless a clear arrives in the same cycle. In IOC_FIRED, a clear returns it to IOC_ARMED.

Top module: `gpio16_ioc`

## Requirements
- R1: After reset, every pin is an input: pad_oe is 0, and the direction register (address 0, bit = 1 means input) reads 0xFFFF. Both interrupt lines are inactive.
- R2: While rst_n is low, pad_oe is 0 at once, without waiting for a clock edge.
- R3: A pin whose direction bit is 0 drives its output-latch bit (address 9) on pad_out with pad_oe set. A pin whose direction bit is 1 has pad_oe clear.
- R4: A read of the port register (address 8) returns the filtered pin values XOR the inversion register (address 1), one cycle after rd_en.
- R5: A pin pulse shorter than FILT_CYCLES clock cycles (after synchronization) is rejected. A level held for at least FILT_CYCLES cycles reaches the port register.
- R6: For a pin whose mode bit (address 4) is 0, both rising and falling changes of the inverted input raise the interrupt of the pin's half.
- R7: For a pin whose mode bit is 1, the interrupt fires while the inverted input differs from the default-compare bit (address 3). A persistent mismatch fires again after each clear. The inversion register takes part in this comparison.
- R8: Only pins with both the enable bit (address 2) and the direction bit set can raise an interrupt. Changes on other pins leave the interrupt inactive and the flag register (address 6) at zero.
- R9: While an interrupt is pending, the flag register and the capture register (address 7) hold the values from the firing cycle. Later pin changes are not recorded.
- R10: A read of the capture register or the port register clears the pending interrupt of both halves on the following cycle and re-arms detection.
- R11: With the mirror bit (config register address 5, bit 0) clear, half A drives only int_a and half B drives only int_b.
- R12: With the mirror bit set, an interrupt from either half asserts both lines.
- R13: Config bits 2:1 select the line drive. 00 means active-low push-pull, 01 means active-high push-pull, and 10 means open-drain: the output level is 0 and the enable is high only while the line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous clear; also forces pad_oe low at once |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| pad_in | input | 16 | Pin input values |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin output enables |
| int_a_o | output | 1 | Interrupt line A level |
| int_a_oe | output | 1 | Interrupt line A enable |
| int_b_o | output | 1 | Interrupt line B level |
| int_b_oe | output | 1 | Interrupt line B enable |

## Verification
Several properties are checked on every cycle: the pins are released during reset, the open-drain level is always low, the two lines are equal while mirrored, the flag register holds steady while an interrupt is pending, a fired interrupt always carries a nonzero flag, and a clear always empties the pending state. Only the bench scenarios can show the rest. These are glitch rejection, the choice between change mode and compare mode, the masking of disabled and output pins, a persistent compare mismatch firing again, and the effect of inversion on reads and on comparison.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_DIR  = 4'd0;
    localparam logic [REG_AW-1:0] A_INV  = 4'd1;
    localparam logic [REG_AW-1:0] A_IEN  = 4'd2;
    localparam logic [REG_AW-1:0] A_DEFV = 4'd3;
    localparam logic [REG_AW-1:0] A_MODE = 4'd4;
    localparam logic [REG_AW-1:0] A_CFG  = 4'd5;
    localparam logic [REG_AW-1:0] A_FLAG = 4'd6;
    localparam logic [REG_AW-1:0] A_CAPT = 4'd7;
    localparam logic [REG_AW-1:0] A_PORT = 4'd8;
    localparam logic [REG_AW-1:0] A_OLAT = 4'd9;

    typedef enum logic [1:0] {
        DRV_LOW  = 2'b00,
        DRV_HIGH = 2'b01,
        DRV_OPEN = 2'b10
    } drv_e;

    typedef enum logic [1:0] {
        IOC_IDLE  = 2'b00,
        IOC_ARMED = 2'b01,
        IOC_FIRED = 2'b10
    } ioc_state_e;
endpackage

// File: rtl/gpio_filter.sv
module gpio_filter #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            cnt   <= '0;
            dout  <= 1'b0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
            if (sync2 == dout) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                dout <= sync2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_ioc_half.sv
module gpio_ioc_half
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seen,
    input  logic [W-1:0] is_in,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] defv,
    input  logic         clr,
    output logic         fired,
    output logic [W-1:0] flag,
    output logic [W-1:0] capt
);
    ioc_state_e   state, state_nx;
    logic [W-1:0] prev;
    logic [W-1:0] diff;
    logic [W-1:0] hit;

    assign diff = (mode & (seen ^ defv)) | (~mode & (seen ^ prev));
    assign hit  = diff & ien & is_in;

    always_comb begin
        state_nx = state;
        unique case (state)
            IOC_IDLE:  state_nx = IOC_ARMED;
            IOC_ARMED: if (!clr && (|hit)) state_nx = IOC_FIRED;
            IOC_FIRED: if (clr) state_nx = IOC_ARMED;
            default:   state_nx = IOC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IOC_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            flag <= '0;
            capt <= '0;
        end else begin
            prev <= seen;
            if (state == IOC_ARMED && !clr && (|hit)) begin
                flag <= hit;
                capt <= seen;
            end else if (state == IOC_FIRED && clr) begin
                flag <= '0;
            end
        end
    end

    assign fired = (state == IOC_FIRED);
endmodule

// File: rtl/gpio_int_drive.sv
module gpio_int_drive
    import gpio_pkg::*;
(
    input  logic       act_a,
    input  logic       act_b,
    input  logic       mirror,
    input  logic [1:0] style,
    output logic [1:0] int_o,
    output logic [1:0] int_oe
);
    logic [1:0] act;

    assign act[0] = mirror ? (act_a | act_b) : act_a;
    assign act[1] = mirror ? (act_a | act_b) : act_b;

    for (genvar L = 0; L < 2; L++) begin : g_line
        always_comb begin
            unique case (style)
                DRV_HIGH: begin int_o[L] = act[L];  int_oe[L] = 1'b1;   end
                DRV_OPEN: begin int_o[L] = 1'b0;    int_oe[L] = act[L]; end
                default:  begin int_o[L] = ~act[L]; int_oe[L] = 1'b1;   end
            endcase
        end
    end
endmodule

// File: rtl/gpio16_ioc.sv
module gpio16_ioc
    import gpio_pkg::*;
#(
    parameter int FILT_CYCLES = 3,
    parameter int HALF_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [2*HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] rdata,
    input  logic [2*HALF_W-1:0] pad_in,
    output logic [2*HALF_W-1:0] pad_out,
    output logic [2*HALF_W-1:0] pad_oe,
    output logic                int_a_o,
    output logic                int_a_oe,
    output logic                int_b_o,
    output logic                int_b_oe
);
    localparam int PW = 2 * HALF_W;

    logic [PW-1:0] dir_q, inv_q, ien_q, defv_q, mode_q, olat_q;
    logic [2:0]    cfg_q;
    logic [PW-1:0] filt, seen, flag_w, capt_w;
    logic [1:0]    fired_w;
    logic          clr;
    logic          cfg_mirror;
    logic [1:0]    cfg_style;
    logic [1:0]    int_o_w, int_oe_w;
    logic [PW-1:0] rd_mux;

    assign cfg_mirror = cfg_q[0];
    assign cfg_style  = cfg_q[2:1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            inv_q  <= '0;
            ien_q  <= '0;
            defv_q <= '0;
            mode_q <= '0;
            olat_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_DIR:   dir_q  <= wdata;
                A_INV:   inv_q  <= wdata;
                A_IEN:   ien_q  <= wdata;
                A_DEFV:  defv_q <= wdata;
                A_MODE:  mode_q <= wdata;
                A_CFG:   cfg_q  <= wdata[2:0];
                A_PORT:  olat_q <= wdata;
                A_OLAT:  olat_q <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_filt
        gpio_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pad_in[i]),
            .dout (filt[i])
        );
    end

    assign seen = filt ^ inv_q;
    assign clr  = rst_n && rd_en && (addr == A_CAPT || addr == A_PORT);

    for (genvar h = 0; h < 2; h++) begin : g_half
        gpio_ioc_half #(.W(HALF_W)) u_half (
            .clk  (clk),
            .rst_n(rst_n),
            .seen (seen[h*HALF_W +: HALF_W]),
            .is_in(dir_q[h*HALF_W +: HALF_W]),
            .ien  (ien_q[h*HALF_W +: HALF_W]),
            .mode (mode_q[h*HALF_W +: HALF_W]),
            .defv (defv_q[h*HALF_W +: HALF_W]),
            .clr  (clr),
            .fired(fired_w[h]),
            .flag (flag_w[h*HALF_W +: HALF_W]),
            .capt (capt_w[h*HALF_W +: HALF_W])
        );
    end

    gpio_int_drive u_drv (
        .act_a (fired_w[0]),
        .act_b (fired_w[1]),
        .mirror(cfg_mirror),
        .style (cfg_style),
        .int_o (int_o_w),
        .int_oe(int_oe_w)
    );

    assign int_a_o  = int_o_w[0];
    assign int_a_oe = int_oe_w[0];
    assign int_b_o  = int_o_w[1];
    assign int_b_oe = int_oe_w[1];

    always_comb begin
        case (addr)
            A_DIR:   rd_mux = dir_q;
            A_INV:   rd_mux = inv_q;
            A_IEN:   rd_mux = ien_q;
            A_DEFV:  rd_mux = defv_q;
            A_MODE:  rd_mux = mode_q;
            A_CFG:   rd_mux = PW'(cfg_q);
            A_FLAG:  rd_mux = flag_w;
            A_CAPT:  rd_mux = capt_w;
            A_PORT:  rd_mux = seen;
            A_OLAT:  rd_mux = olat_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign pad_out = olat_q;
    assign pad_oe  = rst_n ? ~dir_q : '0;
endmodule

// File: rtl/gpio16_ioc_chk.sv
module gpio16_ioc_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] pad_oe,
    input logic          int_a_o,
    input logic          int_a_oe,
    input logic          int_b_o,
    input logic          int_b_oe,
    input logic          cfg_mirror,
    input logic [1:0]    cfg_style,
    input logic [1:0]    fired,
    input logic [PW-1:0] flag,
    input logic          clr
);
    localparam int HW = PW / 2;

    a_r2_reset_hiz: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0));

    a_r13_od_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_style == 2'b10) |-> (!int_a_o && !int_b_o));

    a_r13_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_style == 2'b10 && !cfg_mirror && !fired[0]) |-> !int_a_oe);

    a_r12_mirror_equal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mirror |-> (int_a_o == int_b_o && int_a_oe == int_b_oe));

    a_r9_flag_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (fired[0] && !clr) |=> $stable(flag[HW-1:0]));

    a_r9_flag_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (fired[1] && !clr) |=> $stable(flag[PW-1:HW]));

    a_r9_fire_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired[0]) |-> (flag[HW-1:0] != '0));

    a_r10_clear_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fired == 2'b00));
endmodule

bind gpio16_ioc gpio16_ioc_chk #(.PW(2*HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_oe    (pad_oe),
    .int_a_o   (int_a_o),
    .int_a_oe  (int_a_oe),
    .int_b_o   (int_b_o),
    .int_b_oe  (int_b_oe),
    .cfg_mirror(cfg_mirror),
    .cfg_style (cfg_style),
    .fired     (fired_w),
    .flag      (flag_w),
    .clr       (clr)
);

// File: tb/tb_gpio16_ioc.sv
module tb_gpio16_ioc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic [15:0] pad_in = '0, pad_out, pad_oe;
    logic        int_a_o, int_a_oe, int_b_o, int_b_oe;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio16_ioc dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .int_a_o(int_a_o), .int_a_oe(int_a_oe),
        .int_b_o(int_b_o), .int_b_oe(int_b_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R1 pad_oe", pad_oe, 16'h0000);
        chk("R1 int_a inactive low-style", {15'b0, int_a_o}, 16'h0001);
        chk("R1 int_b inactive low-style", {15'b0, int_b_o}, 16'h0001);
        rd(4'd0, d);
        chk("R1 dir", d, 16'hFFFF);
    endtask

    task automatic t_output;
        wr(4'd9, 16'hA5C3);
        wr(4'd0, 16'h00FF);
        chk("R3 pad_oe", pad_oe, 16'hFF00);
        chk("R3 pad_out", pad_out, 16'hA5C3);
        wr(4'd0, 16'hFFFF);
        chk("R3 oe released", pad_oe, 16'h0000);
    endtask

    task automatic t_port_inv;
        logic [15:0] d;
        pad_in = 16'h00F0;
        wr(4'd1, 16'h000F);
        idle(10);
        rd(4'd8, d);
        chk("R4 port xor inv", d, 16'h00FF);
        wr(4'd1, 16'h0000);
        pad_in = 16'h0000;
        idle(10);
        rd(4'd8, d);
        chk("R4 port plain", d, 16'h0000);
    endtask

    task automatic t_glitch;
        logic [15:0] d;
        wr(4'd5, 16'h0002);
        wr(4'd4, 16'h0000);
        wr(4'd2, 16'h0001);
        @(negedge clk); pad_in[0] = 1'b1;
        idle(2);
        pad_in[0] = 1'b0;
        idle(10);
        rd(4'd8, d);
        chk("R5 short pulse rejected", d, 16'h0000);
        chk("R5 no interrupt from glitch", {15'b0, int_a_o}, 16'h0000);
        pad_in[0] = 1'b1;
        idle(3);
        pad_in[0] = 1'b0;
        idle(10);
        rd(4'd6, d);
        chk("R5 full-width pulse seen", d, 16'h0001);
        rd(4'd8, d);
    endtask

    task automatic t_change;
        logic [15:0] d;
        idle(3);
        pad_in[0] = 1'b1;
        idle(10);
        chk("R6 int_a rise", {15'b0, int_a_o}, 16'h0001);
        chk("R11 int_b quiet", {15'b0, int_b_o}, 16'h0000);
        rd(4'd6, d);
        chk("R6 flag", d, 16'h0001);
        rd(4'd7, d);
        chk("R6 capture", d, 16'h0001);
        chk("R10 cleared by capture read", {15'b0, int_a_o}, 16'h0000);
        pad_in[0] = 1'b0;
        idle(10);
        chk("R6 falling change fires", {15'b0, int_a_o}, 16'h0001);
        rd(4'd8, d);
        chk("R10 cleared by port read", {15'b0, int_a_o}, 16'h0000);
    endtask

    task automatic t_hold;
        logic [15:0] d;
        wr(4'd2, 16'h0003);
        pad_in[0] = 1'b1;
        idle(10);
        pad_in[1] = 1'b1;
        idle(10);
        rd(4'd6, d);
        chk("R9 flag held", d, 16'h0001);
        rd(4'd7, d);
        chk("R9 capture held", d, 16'h0001);
        idle(5);
        chk("R9 later change not recorded", {15'b0, int_a_o}, 16'h0000);
        wr(4'd2, 16'h0000);
        pad_in = 16'h0000;
        idle(10);
    endtask

    task automatic t_mask;
        logic [15:0] d;
        wr(4'd0, 16'hFFF7);
        wr(4'd2, 16'h0009);
        idle(3);
        pad_in[2] = 1'b1;
        pad_in[3] = 1'b1;
        idle(10);
        chk("R8 no interrupt", {15'b0, int_a_o}, 16'h0000);
        rd(4'd6, d);
        chk("R8 flag zero", d, 16'h0000);
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'hFFFF);
        pad_in = 16'h0000;
        idle(10);
    endtask

    task automatic t_compare;
        logic [15:0] d;
        wr(4'd3, 16'h0000);
        wr(4'd4, 16'h0100);
        wr(4'd2, 16'h0100);
        idle(5);
        chk("R7 match no interrupt", {15'b0, int_b_o}, 16'h0000);
        pad_in[8] = 1'b1;
        idle(10);
        chk("R7 mismatch fires B", {15'b0, int_b_o}, 16'h0001);
        chk("R11 A quiet", {15'b0, int_a_o}, 16'h0000);
        rd(4'd8, d);
        chk("R7 port value", d, 16'h0100);
        idle(5);
        chk("R7 persistent mismatch refires", {15'b0, int_b_o}, 16'h0001);
        wr(4'd1, 16'h0100);
        rd(4'd8, d);
        idle(10);
        chk("R7 inversion restores match", {15'b0, int_b_o}, 16'h0000);
    endtask

    task automatic t_mirror_styles;
        logic [15:0] d;
        wr(4'd3, 16'h0100);
        idle(5);
        wr(4'd5, 16'h0003);
        chk("R12 mirror A", {15'b0, int_a_o}, 16'h0001);
        chk("R12 mirror B", {15'b0, int_b_o}, 16'h0001);
        wr(4'd5, 16'h0004);
        chk("R13 od B enabled", {15'b0, int_b_oe}, 16'h0001);
        chk("R13 od B low", {15'b0, int_b_o}, 16'h0000);
        chk("R13 od A released", {15'b0, int_a_oe}, 16'h0000);
        wr(4'd5, 16'h0000);
        chk("R13 low-style B active", {int_b_oe, int_b_o}, 16'h0002);
        chk("R13 low-style A idle", {15'b0, int_a_o}, 16'h0001);
        wr(4'd2, 16'h0000);
        rd(4'd8, d);
    endtask

    task automatic t_reset_hiz;
        logic [15:0] d;
        wr(4'd0, 16'h0000);
        chk("R3 all outputs", pad_oe, 16'hFFFF);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R2 immediate hiz", pad_oe, 16'h0000);
        idle(2);
        rst_n = 1'b1;
        rd(4'd0, d);
        chk("R1 dir after reset", d, 16'hFFFF);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_output();
        t_port_inv();
        t_glitch();
        t_change();
        t_hold();
        t_mask();
        t_compare();
        t_mirror_styles();
        t_reset_hiz();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule